// File: doc/BRIEF.md
# Packed halfword saturating exchange unit

This block runs four operations on a pair of 32-bit words, each word holding two 16-bit lanes. In every operation the lanes cross over. The low lane of operand A is combined with the high lane of operand B, and the high lane of A is combined with the low lane of B. One of these two lane results is a sum and the other is a difference. Each lane result is clamped on its own, to the signed or the unsigned 16-bit range.

The unit sits in an execute stage. It takes an operand pair, an opcode, a condition-passed flag and three register indices, all qualified by a valid strobe. One clock later it returns:
- the packed result,
- a registered valid,
- a write-enable for the destination,
- a flag that marks the operation as unpredictable when any index names register 15.

Top module: `hw_xsat_unit`

## Requirements
- R1: With op_i = 2'b00, result_o[15:0] = sat_s16(A[15:0] − B[31:16]) and result_o[31:16] = sat_s16(A[31:16] + B[15:0]), with every lane taken as signed.
- R2: With op_i = 2'b01, result_o[15:0] = sat_s16(A[15:0] + B[31:16]) and result_o[31:16] = sat_s16(A[31:16] − B[15:0]), with every lane taken as signed.
- R3: A signed lane result above 32767 gives 16'h7FFF, and one below −32768 gives 16'h8000. Each lane clamps independently of the other.
- R4: With op_i = 2'b10 the lane pairing is that of R1, and with op_i = 2'b11 it is that of R2. In both cases the lanes are zero-extended and the result is clamped to 0..65535, so a negative difference gives 16'h0000.
- R5: If any of rd_idx_i, rn_idx_i or rm_idx_i equals 15 on an accepted operation, unpred_o is 1 and wr_en_o is 0 in the following cycle.
- R6: If cond_pass_i is 0 on an accepted operation, wr_en_o is 0 in the following cycle.
- R7: valid_o is valid_i delayed by one clock. wr_en_o is 1 only when valid_o is 1.
- R8: While rst_ni is low, valid_o, wr_en_o, unpred_o and result_o are all 0.
- R9: In a cycle after valid_i was low, result_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 2 | 00 signed add/sub, 01 signed sub/add, 10 unsigned add/sub, 11 unsigned sub/add |
| cond_pass_i | input | 1 | Condition evaluated true |
| rd_idx_i | input | 4 | Destination register index |
| rn_idx_i | input | 4 | First source register index |
| rm_idx_i | input | 4 | Second source register index |
| opa_i | input | 32 | Operand A, two packed lanes |
| opb_i | input | 32 | Operand B, two packed lanes |
| result_o | output | 32 | Packed saturated result |
| wr_en_o | output | 1 | Destination write enable |
| valid_o | output | 1 | Result valid |
| unpred_o | output | 1 | Unpredictable register use |

## Verification
Every stage is either combinational or a single register, so any fault appears at the ports exactly one clock after the operation that exposes it.

Faults and how they show:
- **Wrong lane pairing or swapped add/subtract:** shows as a wrong lane value on the first operation with distinct lanes.
- **Wrong extension or clamp bound:** needs operands near the range edges, such as 7FFF+1, 8000−1, 0−1 and FFFF+FFFF. These are driven on purpose, ahead of the random traffic.
- **Stuck write-enable or unpredictable flag:** shows in the cycle after an operation that has a failed condition or a register-15 index.
- **Stale capture or wrong result hold:** shows in the cycle after any gap in valid_i.

// File: rtl/hw_xsat_pkg.sv
package hw_xsat_pkg;

  typedef enum logic [1:0] {
    XOP_S_ADDSUB = 2'b00,
    XOP_S_SUBADD = 2'b01,
    XOP_U_ADDSUB = 2'b10,
    XOP_U_SUBADD = 2'b11
  } xop_e;

  function automatic logic xop_unsigned(input xop_e op);
    return op[1];
  endfunction

  // lane 0 subtracts for the add/sub forms, lane 1 for the sub/add forms
  function automatic logic xop_lane_sub(input xop_e op, input int lane);
    return (lane == 0) ? ~op[0] : op[0];
  endfunction

endpackage

// File: rtl/hw_xsat_lane.sv
module hw_xsat_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] x_i,
  input  logic [LANE_W-1:0] y_i,
  input  logic              sub_i,
  input  logic              uns_i,
  output logic [LANE_W-1:0] z_o
);
  // two guard bits cover both unsigned and signed ranges
  localparam int unsigned EW = LANE_W + 2;
  localparam logic signed [EW-1:0] SMAX = {3'b000, {(LANE_W-1){1'b1}}};
  localparam logic signed [EW-1:0] SMIN = {3'b111, {(LANE_W-1){1'b0}}};
  localparam logic signed [EW-1:0] UMAX = {2'b00, {LANE_W{1'b1}}};

  logic signed [EW-1:0] xe, ye, raw;

  always_comb begin
    xe  = uns_i ? {2'b00, x_i} : {{2{x_i[LANE_W-1]}}, x_i};
    ye  = uns_i ? {2'b00, y_i} : {{2{y_i[LANE_W-1]}}, y_i};
    raw = sub_i ? (xe - ye) : (xe + ye);
  end

  always_comb begin
    if (uns_i) begin
      if (raw < 0)         z_o = '0;
      else if (raw > UMAX) z_o = '1;
      else                 z_o = raw[LANE_W-1:0];
    end else begin
      if (raw > SMAX)      z_o = {1'b0, {(LANE_W-1){1'b1}}};
      else if (raw < SMIN) z_o = {1'b1, {(LANE_W-1){1'b0}}};
      else                 z_o = raw[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/hw_xsat_guard.sv
module hw_xsat_guard #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned N_IDX    = 3,
  parameter int unsigned RESV_IDX = 15
) (
  input  logic [N_IDX-1:0][IDX_W-1:0] idx_i,
  output logic                        hit_o
);
  logic [N_IDX-1:0] hit_v;

  for (genvar g = 0; g < N_IDX; g++) begin : g_cmp
    assign hit_v[g] = (idx_i[g] == IDX_W'(RESV_IDX));
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/hw_xsat_unit.sv
module hw_xsat_unit
  import hw_xsat_pkg::*;
#(
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned RESV_IDX = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [1:0]            op_i,
  input  logic                  cond_pass_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  input  logic [IDX_W-1:0]      rn_idx_i,
  input  logic [IDX_W-1:0]      rm_idx_i,
  input  logic [2*LANE_W-1:0]   opa_i,
  input  logic [2*LANE_W-1:0]   opb_i,
  output logic [2*LANE_W-1:0]   result_o,
  output logic                  wr_en_o,
  output logic                  valid_o,
  output logic                  unpred_o
);
  localparam int unsigned N_LANE = 2;
  localparam int unsigned DW     = N_LANE * LANE_W;

  xop_e            op;
  logic [DW-1:0]   res_d;
  logic            resv_hit;

  assign op = xop_e'(op_i);

  // exchange: lane g of A pairs with lane (1-g) of B
  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    hw_xsat_lane #(.LANE_W(LANE_W)) u_lane (
      .x_i   (opa_i[g*LANE_W +: LANE_W]),
      .y_i   (opb_i[(N_LANE-1-g)*LANE_W +: LANE_W]),
      .sub_i (xop_lane_sub(op, g)),
      .uns_i (xop_unsigned(op)),
      .z_o   (res_d[g*LANE_W +: LANE_W])
    );
  end

  hw_xsat_guard #(
    .IDX_W    (IDX_W),
    .N_IDX    (3),
    .RESV_IDX (RESV_IDX)
  ) u_guard (
    .idx_i ({rd_idx_i, rn_idx_i, rm_idx_i}),
    .hit_o (resv_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      unpred_o <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i;
      wr_en_o  <= valid_i & cond_pass_i & ~resv_hit;
      unpred_o <= valid_i & resv_hit;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/hw_xsat_unit_chk.sv
module hw_xsat_unit_chk #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [1:0]          op_i,
  input logic                cond_pass_i,
  input logic [IDX_W-1:0]    rd_idx_i,
  input logic [IDX_W-1:0]    rn_idx_i,
  input logic [IDX_W-1:0]    rm_idx_i,
  input logic [2*LANE_W-1:0] opa_i,
  input logic [2*LANE_W-1:0] opb_i,
  input logic [2*LANE_W-1:0] result_o,
  input logic                wr_en_o,
  input logic                valid_o,
  input logic                unpred_o
);
  localparam logic [IDX_W-1:0] R15 = IDX_W'(15);

  // R5
  unpred_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (rd_idx_i == R15 || rn_idx_i == R15 || rm_idx_i == R15))
    |=> (unpred_o && !wr_en_o));

  // R6
  cond_fail_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass_i) |=> !wr_en_o);

  // R7
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R7
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R7
  write_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);

  // R4
  unsigned_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && opa_i[LANE_W-1:0] < opb_i[2*LANE_W-1:LANE_W])
    |=> (result_o[LANE_W-1:0] == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

endmodule

bind hw_xsat_unit hw_xsat_unit_chk #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .cond_pass_i(cond_pass_i), .rd_idx_i(rd_idx_i), .rn_idx_i(rn_idx_i),
  .rm_idx_i(rm_idx_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
  .wr_en_o(wr_en_o), .valid_o(valid_o), .unpred_o(unpred_o)
);

// File: tb/hw_xsat_unit_bench.sv
module hw_xsat_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        cond_pass_i = 1'b0;
  logic [3:0]  rd_idx_i = 4'd0, rn_idx_i = 4'd0, rm_idx_i = 4'd0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, valid_o, unpred_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // pending expectation for the next sample
  bit          e_valid = 1'b0, e_wr = 1'b0, e_unp = 1'b0, e_sat = 1'b0;
  logic [1:0]  e_op = 2'b00;
  logic [31:0] e_res = '0;

  always #4 clk_i = ~clk_i;

  hw_xsat_unit u_hw_xsat_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .cond_pass_i(cond_pass_i), .rd_idx_i(rd_idx_i), .rn_idx_i(rn_idx_i),
    .rm_idx_i(rm_idx_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .valid_o(valid_o), .unpred_o(unpred_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sat16(input int v, input bit uns, inout bit s);
    if (uns) begin
      if (v < 0)      begin s = 1; return 16'h0000; end
      if (v > 65535)  begin s = 1; return 16'hFFFF; end
    end else begin
      if (v > 32767)  begin s = 1; return 16'h7FFF; end
      if (v < -32768) begin s = 1; return 16'h8000; end
    end
    return v[15:0];
  endfunction

  function automatic logic [31:0] ref_calc(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, output bit s);
    int al, ah, bl, bh, lo, hi;
    bit uns = op[1];
    s  = 0;
    al = uns ? int'(a[15:0])  : int'($signed(a[15:0]));
    ah = uns ? int'(a[31:16]) : int'($signed(a[31:16]));
    bl = uns ? int'(b[15:0])  : int'($signed(b[15:0]));
    bh = uns ? int'(b[31:16]) : int'($signed(b[31:16]));
    lo = op[0] ? al + bh : al - bh;
    hi = op[0] ? ah - bl : ah + bl;
    return {sat16(hi, uns, s), sat16(lo, uns, s)};
  endfunction

  task automatic sample();
    string rt;
    chk("R7", "valid_o", 32'(valid_o), 32'(e_valid));
    if (e_valid) begin
      chk("R5", "unpred_o", 32'(unpred_o), 32'(e_unp));
      chk(e_unp ? "R5" : "R6", "wr_en_o", 32'(wr_en_o), 32'(e_wr));
      if (e_op[1])     rt = "R4";
      else if (e_sat)  rt = "R3";
      else if (e_op[0]) rt = "R2";
      else             rt = "R1";
      chk(rt, "result_o", result_o, e_res);
    end else begin
      chk("R7", "wr_en_o idle", 32'(wr_en_o), 32'd0);
      chk("R9", "result_o hold", result_o, e_res);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input bit cp,
                      input logic [3:0] rd, input logic [3:0] rn, input logic [3:0] rm,
                      input logic [31:0] a, input logic [31:0] b);
    bit s;
    logic [31:0] r;
    @(negedge clk_i);
    sample();
    valid_i = v; op_i = op; cond_pass_i = cp;
    rd_idx_i = rd; rn_idx_i = rn; rm_idx_i = rm; opa_i = a; opb_i = b;
    e_valid = v;
    if (v) begin
      r     = ref_calc(op, a, b, s);
      e_res = r; e_sat = s; e_op = op;
      e_unp = (rd == 4'd15) || (rn == 4'd15) || (rm == 4'd15);
      e_wr  = cp && !e_unp;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8", "valid_o in reset", 32'(valid_o), 32'd0);
    chk("R8", "wr_en_o in reset", 32'(wr_en_o), 32'd0);
    chk("R8", "unpred_o in reset", 32'(unpred_o), 32'd0);
    chk("R8", "result_o in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    // R1 plain
    step(1, 2'b00, 1, 4'd1, 4'd2, 4'd3, 32'h0005_0010, 32'h0003_0004);
    // R2 plain
    step(1, 2'b01, 1, 4'd1, 4'd2, 4'd3, 32'h0005_0010, 32'h0003_0004);
    // R3 signed clamps both ways per lane
    step(1, 2'b00, 1, 4'd0, 4'd1, 4'd2, 32'h7FFF_8000, 32'h0001_0001);
    step(1, 2'b01, 1, 4'd0, 4'd1, 4'd2, 32'h8000_7FFF, 32'h0001_0001);
    step(1, 2'b00, 1, 4'd0, 4'd1, 4'd2, 32'h8000_7FFF, 32'hFFFF_FFFF);
    // R4 unsigned floor and ceiling
    step(1, 2'b10, 1, 4'd4, 4'd5, 4'd6, 32'hFFFF_0000, 32'h0001_FFFF);
    step(1, 2'b11, 1, 4'd4, 4'd5, 4'd6, 32'h0000_FFFF, 32'hFFFF_0001);
    step(1, 2'b10, 1, 4'd4, 4'd5, 4'd6, 32'h1234_8000, 32'h8000_4321);
    // R9 gap holds
    step(0, 2'b11, 1, 4'd0, 4'd0, 4'd0, 32'hDEAD_BEEF, 32'h1234_5678);
    step(0, 2'b00, 0, 4'd0, 4'd0, 4'd0, 32'h0, 32'h0);
    // R5 register 15 in each slot
    step(1, 2'b00, 1, 4'd15, 4'd1, 4'd2, 32'h1, 32'h2);
    step(1, 2'b01, 1, 4'd1, 4'd15, 4'd2, 32'h1, 32'h2);
    step(1, 2'b10, 1, 4'd1, 4'd2, 4'd15, 32'h1, 32'h2);
    // R6 condition fails
    step(1, 2'b11, 0, 4'd1, 4'd2, 4'd3, 32'h00FF_00FF, 32'h0F0F_0F0F);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 2'($urandom), ($urandom % 5) != 0,
           4'($urandom), 4'($urandom), 4'($urandom), $urandom, $urandom);
    end
    step(0, 2'b00, 0, 4'd0, 4'd0, 4'd0, 32'h0, 32'h0);
    @(negedge clk_i);
    sample();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule